// File: doc/BRIEF.md
# SMRAM Access Control Unit

This block holds the two byte-wide configuration registers that govern system-management RAM and turns them, together with the address of each access and the processor's management-mode flag, into a routing decision. Three regions are controlled: the 128 KB legacy window at 0xA0000, a 128 KB high alias of that window at 0xFEDA0000, and a TSEG region carved from the top of memory below 4 GB. Each access is routed to RAM, to PCI/legacy space, or to a blackhole that returns all ones and drops writes. If the address lies in none of the three regions, the block leaves it to the normal decode.

Normal-mode and management-mode accesses are resolved separately. Normal code sees the windows only when the open bit is set. Management code sees them whenever the global enable is set. A high-enable bit selects whether the low or the high window carries the RAM. A one-way lock bit clears the open bit at once and freezes both registers until reset. The surrounding fabric writes the registers through a simple write port, reads them back on two output buses, and consults the registered route for every access.

Top module: `smram_gate`

## Requirements
- R1: The route output uses 0 = none (unclaimed), 1 = RAM, 2 = PCI/legacy and 3 = blackhole. The low window spans 0xA0000 to 0xBFFFF and the high alias spans 0xFEDA0000 to 0xFEDBFFFF. Any address outside both windows and outside an active TSEG routes to 0.
- R2: In normal mode with open (control bit 6) set, the low window routes to RAM when high-enable (extended bit 7) is 0 and to PCI when it is 1. The high alias routes to RAM when high-enable is 1 and to none when it is 0.
- R3: In normal mode with open clear, the low window routes to PCI and the high alias routes to none.
- R4: In management mode with global enable (control bit 3) set, the low window routes to RAM if high-enable is 0 and to PCI otherwise, and the high alias routes to RAM if high-enable is 1 and to none otherwise. With global enable clear, the low window routes to PCI and the high alias to none.
- R5: TSEG is active only when TSEG enable (extended bit 0) and global enable are both set. Its size code (extended bits 2:1) selects 0 = 1 MB, 1 = 2 MB, 2 = 8 MB and 3 = the extended size parameter in MB.
- R6: An active TSEG covers [below-4G size minus TSEG size, below-4G size). In that range, normal mode routes to blackhole and management mode routes to RAM.
- R7: Reset clears both registers and the lock, and restores the full write masks.
- R8: Only control bits 6, 4 and 3 and extended bits 7, 2:1 and 0 are writable, and other bits read 0. A write that leaves lock (control bit 4) set clears open in the same write. While lock is set, writes to either register are ignored.
- R9: A register write is visible on the readback buses after the clock edge that takes it. The route output is registered and reflects the address, mode and registers one edge after they are presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Register select: 0 control, 1 extended |
| wr_data | input | 8 | Write data |
| smm | input | 1 | Access is in management mode |
| addr | input | AW | Access address |
| low_mem_size | input | AW | Memory size below 4 GB, in bytes |
| ctl_q | output | 8 | Control register readback |
| ext_q | output | 8 | Extended register readback |
| route_q | output | 2 | Registered route decision |

## Verification
The bench builds the block with a 32-bit address and an extended TSEG size of 4 MB. A 4 MB TSEG is distinct from all three fixed sizes, so each size code yields its own base, and the bench probes the addresses on either side of each base. The below-4G size is held at 2 GB, which puts every TSEG base well clear of the legacy windows.

// File: rtl/smr_pkg.sv
package smr_pkg;
  typedef enum logic [1:0] {
    RT_NONE = 2'd0,
    RT_RAM  = 2'd1,
    RT_PCI  = 2'd2,
    RT_HOLE = 2'd3
  } route_e;

  localparam int CTL_OPEN = 6;
  localparam int CTL_LOCK = 4;
  localparam int CTL_GEN  = 3;
  localparam int EXT_HI   = 7;
  localparam int EXT_SZ   = 1;
  localparam int EXT_TEN  = 0;

  typedef struct packed {
    logic       open;
    logic       lock;
    logic       gen;
    logic       hi;
    logic       ten;
    logic [1:0] szc;
  } cfg_t;
endpackage

// File: rtl/smr_cfg_regs.sv
module smr_cfg_regs
  import smr_pkg::*;
#(
  parameter logic [7:0] CTL_FULL_MASK = 8'h58,
  parameter logic [7:0] CTL_LOCK_MASK = 8'h00,
  parameter logic [7:0] EXT_FULL_MASK = 8'h87,
  parameter logic [7:0] EXT_LOCK_MASK = 8'h00
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_en,
  input  logic       wr_sel,
  input  logic [7:0] wr_data,
  output logic [7:0] ctl_q,
  output logic [7:0] ext_q,
  output cfg_t       cfg
);
  logic       locked;
  logic [7:0] ctl_mask, ext_mask;
  logic [7:0] ctl_nxt, ext_nxt;

  assign locked   = ctl_q[CTL_LOCK];
  assign ctl_mask = locked ? CTL_LOCK_MASK : CTL_FULL_MASK;
  assign ext_mask = locked ? EXT_LOCK_MASK : EXT_FULL_MASK;

  always_comb begin
    ctl_nxt = (ctl_q & ~ctl_mask) | (wr_data & ctl_mask);
    if (ctl_nxt[CTL_LOCK]) ctl_nxt[CTL_OPEN] = 1'b0;
    ext_nxt = (ext_q & ~ext_mask) | (wr_data & ext_mask);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q <= '0;
      ext_q <= '0;
    end else if (wr_en) begin
      if (!wr_sel) ctl_q <= ctl_nxt;
      else         ext_q <= ext_nxt;
    end
  end

  assign cfg.open = ctl_q[CTL_OPEN];
  assign cfg.lock = ctl_q[CTL_LOCK];
  assign cfg.gen  = ctl_q[CTL_GEN];
  assign cfg.hi   = ext_q[EXT_HI];
  assign cfg.ten  = ext_q[EXT_TEN];
  assign cfg.szc  = ext_q[EXT_SZ +: 2];

  // R8
  lock_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    ctl_q[CTL_LOCK] |=> ctl_q[CTL_LOCK]);
  // R8
  lock_open_chk: assert property (@(posedge clk) disable iff (rst)
    ctl_q[CTL_LOCK] |-> !ctl_q[CTL_OPEN]);
  // R8
  ctl_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    ctl_q[CTL_LOCK] |=> ((ctl_q & ~CTL_LOCK_MASK) == ($past(ctl_q) & ~CTL_LOCK_MASK)));
  // R8
  ext_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    ctl_q[CTL_LOCK] |=> ((ext_q & ~EXT_LOCK_MASK) == ($past(ext_q) & ~EXT_LOCK_MASK)));
endmodule

// File: rtl/smr_tseg.sv
module smr_tseg
  import smr_pkg::*;
#(
  parameter int AW          = 32,
  parameter int EXT_TSEG_MB = 16
) (
  input  cfg_t          cfg,
  input  logic [AW-1:0] addr,
  input  logic [AW-1:0] low_mem_size,
  output logic          hit
);
  localparam int SW = AW + 1;

  logic [15:0]   size_mb;
  logic [SW-1:0] size_b, low_x, base_x;
  logic          active;

  always_comb begin
    unique case (cfg.szc)
      2'd0:    size_mb = 16'd1;
      2'd1:    size_mb = 16'd2;
      2'd2:    size_mb = 16'd8;
      default: size_mb = 16'(EXT_TSEG_MB);
    endcase
  end

  assign active = cfg.ten && cfg.gen;
  assign size_b = SW'(size_mb) << 20;
  assign low_x  = {1'b0, low_mem_size};
  assign base_x = (size_b > low_x) ? '0 : (low_x - size_b);
  assign hit    = active && ({1'b0, addr} >= base_x) && (addr < low_mem_size);
endmodule

// File: rtl/smr_route.sv
module smr_route
  import smr_pkg::*;
#(
  parameter int            AW        = 32,
  parameter logic [AW-1:0] LOW_BASE  = 32'h000A_0000,
  parameter logic [AW-1:0] HIGH_BASE = 32'hFEDA_0000,
  parameter logic [AW-1:0] WIN_BYTES = 32'h0002_0000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          smm,
  input  logic [AW-1:0] addr,
  input  cfg_t          cfg,
  input  logic          tseg_hit,
  output route_e        route_q
);
  localparam logic [AW-1:0] LOW_LAST  = LOW_BASE + WIN_BYTES - 1'b1;
  localparam logic [AW-1:0] HIGH_LAST = HIGH_BASE + WIN_BYTES - 1'b1;

  logic   in_low, in_high;
  route_e route_d;

  assign in_low  = (addr >= LOW_BASE)  && (addr <= LOW_LAST);
  assign in_high = (addr >= HIGH_BASE) && (addr <= HIGH_LAST);

  always_comb begin
    route_d = RT_NONE;
    if (in_low) begin
      if (smm) route_d = (cfg.gen && !cfg.hi) ? RT_RAM : RT_PCI;
      else     route_d = (cfg.open && !cfg.hi) ? RT_RAM : RT_PCI;
    end else if (in_high) begin
      if (smm) route_d = (cfg.gen && cfg.hi) ? RT_RAM : RT_NONE;
      else     route_d = (cfg.open && cfg.hi) ? RT_RAM : RT_NONE;
    end else if (tseg_hit) begin
      route_d = smm ? RT_RAM : RT_HOLE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) route_q <= RT_NONE;
    else     route_q <= route_d;
  end

  // R6
  hole_normal_chk: assert property (@(posedge clk) disable iff (rst)
    (route_q == RT_HOLE) |-> !$past(smm));
  // R4
  smm_gen_off_chk: assert property (@(posedge clk) disable iff (rst)
    (smm && !cfg.gen && (in_low || in_high)) |=> (route_q != RT_RAM));
  // R3
  closed_normal_chk: assert property (@(posedge clk) disable iff (rst)
    (!smm && !cfg.open && (in_low || in_high)) |=> (route_q != RT_RAM));
  // R1
  window_only_chk: assert property (@(posedge clk) disable iff (rst)
    (!in_low && !in_high && !tseg_hit) |=> (route_q == RT_NONE));
endmodule

// File: rtl/smram_gate.sv
module smram_gate
  import smr_pkg::*;
#(
  parameter int            AW            = 32,
  parameter int            EXT_TSEG_MB   = 16,
  parameter logic [AW-1:0] LOW_BASE      = 32'h000A_0000,
  parameter logic [AW-1:0] HIGH_BASE     = 32'hFEDA_0000,
  parameter logic [AW-1:0] WIN_BYTES     = 32'h0002_0000,
  parameter logic [7:0]    CTL_FULL_MASK = 8'h58,
  parameter logic [7:0]    CTL_LOCK_MASK = 8'h00,
  parameter logic [7:0]    EXT_FULL_MASK = 8'h87,
  parameter logic [7:0]    EXT_LOCK_MASK = 8'h00
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic          wr_sel,
  input  logic [7:0]    wr_data,
  input  logic          smm,
  input  logic [AW-1:0] addr,
  input  logic [AW-1:0] low_mem_size,
  output logic [7:0]    ctl_q,
  output logic [7:0]    ext_q,
  output logic [1:0]    route_q
);
  cfg_t   cfg;
  logic   tseg_hit;
  route_e route;

  smr_cfg_regs #(
    .CTL_FULL_MASK(CTL_FULL_MASK), .CTL_LOCK_MASK(CTL_LOCK_MASK),
    .EXT_FULL_MASK(EXT_FULL_MASK), .EXT_LOCK_MASK(EXT_LOCK_MASK)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .ctl_q(ctl_q), .ext_q(ext_q), .cfg(cfg)
  );

  smr_tseg #(.AW(AW), .EXT_TSEG_MB(EXT_TSEG_MB)) u_tseg (
    .cfg(cfg), .addr(addr), .low_mem_size(low_mem_size), .hit(tseg_hit)
  );

  smr_route #(
    .AW(AW), .LOW_BASE(LOW_BASE), .HIGH_BASE(HIGH_BASE), .WIN_BYTES(WIN_BYTES)
  ) u_route (
    .clk(clk), .rst(rst), .smm(smm), .addr(addr), .cfg(cfg),
    .tseg_hit(tseg_hit), .route_q(route)
  );

  assign route_q = route;
endmodule

// File: tb/sim_smram_gate.sv
module sim_smram_gate;
  localparam int CLK_P = 10;
  localparam int AW    = 32;
  localparam int NV    = 24;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0, wr_sel = 1'b0;
  logic [7:0]    wr_data = '0;
  logic          smm = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [AW-1:0] low_mem_size = 32'h8000_0000;
  logic [7:0]    ctl_q, ext_q;
  logic [1:0]    route_q;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  smram_gate #(.AW(AW), .EXT_TSEG_MB(4)) u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .smm(smm), .addr(addr), .low_mem_size(low_mem_size),
    .ctl_q(ctl_q), .ext_q(ext_q), .route_q(route_q)
  );

  // Vector: ctl[54:47] ext[46:39] smm[38] addr[37:6] route[5:4] req[3:0]
  // Route: 0 none, 1 RAM, 2 PCI, 3 hole
  localparam logic [54:0] VEC [NV] = '{
    {8'h00, 8'h00, 1'b0, 32'h000A_0000, 2'd2, 4'd3},  // R3 closed low
    {8'h00, 8'h00, 1'b0, 32'hFEDA_0000, 2'd0, 4'd3},  // R3 closed high
    {8'h40, 8'h00, 1'b0, 32'h000A_0000, 2'd1, 4'd2},  // R2 open low
    {8'h40, 8'h80, 1'b0, 32'h000B_FFFF, 2'd2, 4'd2},  // R2 open hi low
    {8'h40, 8'h80, 1'b0, 32'hFEDA_0000, 2'd1, 4'd2},  // R2 open hi high
    {8'h40, 8'h00, 1'b0, 32'hFEDB_FFFF, 2'd0, 4'd2},  // R2 open high hidden
    {8'h08, 8'h00, 1'b1, 32'h000A_0000, 2'd1, 4'd4},  // R4 smm low
    {8'h08, 8'h80, 1'b1, 32'hFEDB_FFFF, 2'd1, 4'd4},  // R4 smm high
    {8'h08, 8'h80, 1'b1, 32'h000A_0000, 2'd2, 4'd4},  // R4 smm low swapped
    {8'h00, 8'h80, 1'b1, 32'hFEDA_0000, 2'd0, 4'd4},  // R4 gen clear high
    {8'h00, 8'h00, 1'b1, 32'h000A_0000, 2'd2, 4'd4},  // R4 gen clear low
    {8'h08, 8'h01, 1'b0, 32'h7FF0_0000, 2'd3, 4'd6},  // R6 1MB hole
    {8'h08, 8'h01, 1'b0, 32'h7FEF_FFFF, 2'd0, 4'd5},  // R5 below 1MB
    {8'h08, 8'h01, 1'b1, 32'h7FFF_FFFF, 2'd1, 4'd6},  // R6 smm sees RAM
    {8'h08, 8'h03, 1'b0, 32'h7FE0_0000, 2'd3, 4'd5},  // R5 2MB
    {8'h08, 8'h05, 1'b0, 32'h7F80_0000, 2'd3, 4'd5},  // R5 8MB
    {8'h08, 8'h05, 1'b0, 32'h7F7F_FFFF, 2'd0, 4'd5},  // R5 below 8MB
    {8'h08, 8'h07, 1'b0, 32'h7FC0_0000, 2'd3, 4'd5},  // R5 ext 4MB
    {8'h08, 8'h07, 1'b0, 32'h7FBF_FFFF, 2'd0, 4'd5},  // R5 below ext
    {8'h00, 8'h01, 1'b0, 32'h7FF0_0000, 2'd0, 4'd5},  // R5 gen clear
    {8'h08, 8'h00, 1'b0, 32'h7FF0_0000, 2'd0, 4'd5},  // R5 tseg enable clear
    {8'h08, 8'h01, 1'b0, 32'h8000_0000, 2'd0, 4'd6},  // R6 upper bound
    {8'h40, 8'h00, 1'b0, 32'h0009_FFFF, 2'd0, 4'd1},  // R1 below low window
    {8'h40, 8'h00, 1'b0, 32'h000C_0000, 2'd0, 4'd1}   // R1 above low window
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic probe(input logic m, input logic [AW-1:0] a);
    smm = m; addr = a;
    @(negedge clk);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    #(CLK_P * 50000);
    if (!done) begin
      failures++;
      $display("FAIL R9 watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R7 reset state
    check("R7", ctl_q, 8'h00);
    check("R7", ext_q, 8'h00);
    check("R7", route_q, 2'd0);

    for (int i = 0; i < NV; i++) begin
      wr(1'b0, VEC[i][54:47]);
      wr(1'b1, VEC[i][46:39]);
      probe(VEC[i][38], VEC[i][37:6]);
      check($sformatf("R%0d vec%0d", VEC[i][3:0], i), route_q, VEC[i][5:4]);
    end

    // R9 latency: route shows old config one edge after the write edge
    wr(1'b0, 8'h00);
    wr(1'b1, 8'h00);
    probe(1'b0, 32'h000A_0000);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 1'b0; wr_data = 8'h40;
    @(negedge clk);
    wr_en = 1'b0;
    check("R9", ctl_q, 8'h40);
    check("R9", route_q, 2'd2);
    @(negedge clk);
    check("R9", route_q, 2'd1);

    // R8 write masks and lock
    wr(1'b1, 8'hFF);
    check("R8", ext_q, 8'h87);
    wr(1'b1, 8'h00);
    wr(1'b0, 8'hFF);
    check("R8", ctl_q, 8'h18);
    wr(1'b0, 8'h40);
    check("R8", ctl_q, 8'h18);
    wr(1'b1, 8'h81);
    check("R8", ext_q, 8'h00);
    probe(1'b0, 32'h000A_0000);
    check("R8", route_q, 2'd2);
    probe(1'b1, 32'h000A_0000);
    check("R4", route_q, 2'd1);

    // R7 reset clears lock and restores masks
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    check("R7", ctl_q, 8'h00);
    wr(1'b0, 8'h40);
    check("R7", ctl_q, 8'h40);
    wr(1'b1, 8'h81);
    check("R7", ext_q, 8'h81);

    done = 1;
    summary();
    $finish;
  end
endmodule